// File: doc/BRIEF.md
# Video Sync Pulse Conditioner

This block cleans up the separate horizontal and vertical sync lines of an older TTL video source before they reach a capture front end that is strict about sync timing. Both sync inputs are sampled on a fast system clock. Each passes a two-stage synchronizer and a glitch filter. The horizontal sync is then forwarded with its width intact. The vertical sync is rebuilt from scratch: an overly long source pulse, for example one that lasts about fifteen lines, becomes a pulse of a configured number of lines. Each edge of that pulse falls exactly on a horizontal sync leading edge, so the two outputs cannot drift against each other.

Each output can be flipped to active-low for receivers that detect sync on a falling transition. The new setting is applied only at a frame start. The source polarity can also be declared active-low per input. A status word reports how many lines the last source vertical pulse spanned. A sticky flag reports lost horizontal sync, and while it is set the vertical output is held inactive. Pixel data does not pass through this block.

Top module: `sync_conditioner`

## Requirements
- R1: After reset `hs_o` and `vs_o` are 0 (active-high, inactive), `vs_width_o` is 0 and `hs_lost_o` is 0.
- R2: A level on either sync input that holds for fewer than `STABLE` (default 3) consecutive system clocks causes no change on any output.
- R3: A horizontal sync pulse of N clocks at the input appears at `hs_o` as a pulse of exactly N clocks.
- R4: The rebuilt vertical pulse lasts exactly `vs_lines_i` horizontal periods. It covers `vs_lines_i` output hsync leading edges, counting the one it starts on, and it ends on the next one. A value of 0 acts as 1.
- R5: The output vertical pulse starts on the first output hsync leading edge at or after the (filtered) input vertical assertion and ends on an output hsync leading edge, in the same clock cycle. This includes the case where the input vsync and hsync assert in the same cycle.
- R6: Each input vertical pulse yields exactly one output pulse of the configured length, whether the input pulse is longer or shorter than that length.
- R7: `hs_out_neg_i` and `vs_out_neg_i` (1 = active-low output) take effect only at the next filtered input vertical assertion. Before that the outputs keep their previous polarity.
- R8: `hs_in_neg_i` and `vs_in_neg_i` (1 = the source sync is active-low) invert the respective input before filtering. An inverted source then gives the same outputs as a non-inverted one.
- R9: `vs_width_o` reports the number of input hsync leading edges seen while the filtered input vsync was asserted. It is updated when the input vsync deasserts and is held otherwise.
- R10: When no hsync leading edge arrives for more than 256 × `timeout_i` clocks, `hs_lost_o` is set and stays set until reset. While it is set, `vs_o` is inactive. `timeout_i` = 0 disables the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_i | input | 1 | Source horizontal sync |
| vs_i | input | 1 | Source vertical sync |
| hs_in_neg_i | input | 1 | 1: source hsync is active low |
| vs_in_neg_i | input | 1 | 1: source vsync is active low |
| hs_out_neg_i | input | 1 | 1: drive hs_o active low (applied at frame start) |
| vs_out_neg_i | input | 1 | 1: drive vs_o active low (applied at frame start) |
| vs_lines_i | input | LINE_W | Output vertical pulse length in lines |
| timeout_i | input | TO_W | Hsync loss timeout in units of 256 clocks, 0 = off |
| hs_o | output | 1 | Conditioned horizontal sync |
| vs_o | output | 1 | Rebuilt, line-locked vertical sync |
| vs_width_o | output | LINE_W | Measured width of last input vsync in lines |
| hs_lost_o | output | 1 | Sticky hsync-loss flag |

## Verification
The input vertical assertion and an hsync leading edge can reach the vertical regenerator in the same clock. The pulse must then start on that very edge and not one line later. The same collision decides whether the width counter includes the edge. The bench provokes this by raising both raw inputs on one clock, which gives them identical filter latency. It then checks three things: the output vertical rising edge is sampled together with an output hsync leading edge, the pulse still spans the configured line count, and the reported width counts the coincident edge but not one that coincides with the deassertion.

// File: rtl/sync_cond_pkg.sv
package sync_cond_pkg;
  typedef enum logic [1:0] {
    VS_IDLE,
    VS_WAIT,
    VS_ACTIVE,
    VS_HOLD
  } vs_state_e;

  localparam int unsigned CH_HS  = 0;
  localparam int unsigned CH_VS  = 1;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/sync_cond_filter.sv
module sync_cond_filter #(
  parameter int unsigned STABLE = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = (STABLE < 2) ? 1 : $clog2(STABLE + 1);

  logic          s1_q, s2_q, filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(STABLE - 1)) begin
        filt_q <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;

  // R2
  filt_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> ($past(s2_q) == filt_q) && ($past(cnt_q) == CW'(STABLE - 1)));

endmodule

// File: rtl/sync_cond_hs_watch.sv
module sync_cond_hs_watch #(
  parameter int unsigned TO_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hs_rise_i,
  input  logic [TO_W-1:0] timeout_i,
  output logic            lost_o
);
  localparam int unsigned CNT_W = TO_W + 9;

  logic [CNT_W-1:0] gap_q;
  logic [CNT_W-1:0] limit;
  logic             lost_q;

  assign limit = {1'b0, timeout_i, 8'h00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      if (hs_rise_i)        gap_q <= '0;
      else if (gap_q != '1) gap_q <= gap_q + 1'b1;
      if (timeout_i != '0 && gap_q > limit) lost_q <= 1'b1;
    end
  end

  assign lost_o = lost_q;

  // R10
  lost_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_q |=> lost_q);

  // R10
  lost_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lost_q) |-> $past(timeout_i) != '0);

endmodule

// File: rtl/sync_cond_vs_regen.sv
module sync_cond_vs_regen
  import sync_cond_pkg::*;
#(
  parameter int unsigned LINE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_rise_i,
  input  logic              vs_rise_i,
  input  logic              vs_fall_i,
  input  logic              vs_lvl_i,
  input  logic              lost_i,
  input  logic [LINE_W-1:0] lines_i,
  output logic              vs_act_o,
  output logic [LINE_W-1:0] width_o
);
  vs_state_e         st_q;
  logic              act_q;
  logic [LINE_W-1:0] cnt_q, meas_q, width_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= VS_IDLE;
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (lost_i) begin
      st_q  <= VS_IDLE;
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        VS_IDLE: begin
          if (vs_rise_i) begin
            if (hs_rise_i) begin
              st_q  <= VS_ACTIVE;
              act_q <= 1'b1;
              cnt_q <= LINE_W'(1);
            end else begin
              st_q <= VS_WAIT;
            end
          end
        end
        VS_WAIT: begin
          if (hs_rise_i) begin
            st_q  <= VS_ACTIVE;
            act_q <= 1'b1;
            cnt_q <= LINE_W'(1);
          end
        end
        VS_ACTIVE: begin
          if (hs_rise_i) begin
            if (cnt_q >= lines_i) begin
              act_q <= 1'b0;
              st_q  <= vs_lvl_i ? VS_HOLD : VS_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        VS_HOLD: begin
          if (!vs_lvl_i) st_q <= VS_IDLE;
        end
        default: st_q <= VS_IDLE;
      endcase
    end
  end

  // input pulse width in lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meas_q  <= '0;
      width_q <= '0;
    end else begin
      if (vs_rise_i)                                 meas_q <= hs_rise_i ? LINE_W'(1) : '0;
      else if (vs_lvl_i && hs_rise_i && meas_q != '1) meas_q <= meas_q + 1'b1;
      if (vs_fall_i) width_q <= meas_q;
    end
  end

  assign vs_act_o = act_q;
  assign width_o  = width_q;

  // R5
  vs_start_on_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(hs_rise_i));

  // R5
  vs_end_on_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> ($past(hs_rise_i) || $past(lost_i)));

  // R10
  vs_forced_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_i |=> !act_q);

  // R9
  width_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(width_q) |-> $past(vs_fall_i));

endmodule

// File: rtl/sync_conditioner.sv
module sync_conditioner
  import sync_cond_pkg::*;
#(
  parameter int unsigned STABLE = 3,
  parameter int unsigned LINE_W = 8,
  parameter int unsigned TO_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_i,
  input  logic              vs_i,
  input  logic              hs_in_neg_i,
  input  logic              vs_in_neg_i,
  input  logic              hs_out_neg_i,
  input  logic              vs_out_neg_i,
  input  logic [LINE_W-1:0] vs_lines_i,
  input  logic [TO_W-1:0]   timeout_i,
  output logic              hs_o,
  output logic              vs_o,
  output logic [LINE_W-1:0] vs_width_o,
  output logic              hs_lost_o
);
  logic [NUM_CH-1:0] raw, filt, filt_d;
  logic              hs_rise, vs_rise, vs_fall;
  logic              hs_neg_q, vs_neg_q;
  logic              vs_act, lost;

  assign raw[CH_HS] = hs_i ^ hs_in_neg_i;
  assign raw[CH_VS] = vs_i ^ vs_in_neg_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    sync_cond_filter #(.STABLE(STABLE)) i_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[g]),
      .filt_o (filt[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_d   <= '0;
      hs_neg_q <= 1'b0;
      vs_neg_q <= 1'b0;
    end else begin
      filt_d <= filt;
      if (vs_rise) begin
        hs_neg_q <= hs_out_neg_i;
        vs_neg_q <= vs_out_neg_i;
      end
    end
  end

  assign hs_rise = filt[CH_HS] & ~filt_d[CH_HS];
  assign vs_rise = filt[CH_VS] & ~filt_d[CH_VS];
  assign vs_fall = ~filt[CH_VS] & filt_d[CH_VS];

  sync_cond_hs_watch #(.TO_W(TO_W)) i_watch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hs_rise_i (hs_rise),
    .timeout_i (timeout_i),
    .lost_o    (lost)
  );

  sync_cond_vs_regen #(.LINE_W(LINE_W)) i_regen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hs_rise_i (hs_rise),
    .vs_rise_i (vs_rise),
    .vs_fall_i (vs_fall),
    .vs_lvl_i  (filt[CH_VS]),
    .lost_i    (lost),
    .lines_i   (vs_lines_i),
    .vs_act_o  (vs_act),
    .width_o   (vs_width_o)
  );

  // hsync delayed one stage so regenerated vsync edges land on it
  assign hs_o      = filt_d[CH_HS] ^ hs_neg_q;
  assign vs_o      = vs_act ^ vs_neg_q;
  assign hs_lost_o = lost;

  // R7
  pol_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({hs_neg_q, vs_neg_q}) |-> $past(vs_rise));

endmodule

// File: tb/test_sync_conditioner.sv
module test_sync_conditioner;
  localparam int LINE = 64;
  localparam int HSW  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs_d = 1'b0, vs_d = 1'b0;
  logic       hs_in_neg = 1'b0, vs_in_neg = 1'b0;
  logic       hs_out_neg = 1'b0, vs_out_neg = 1'b0;
  logic [7:0] lines_cfg = 8'd4;
  logic [7:0] to_cfg = 8'd0;
  logic       hs_o, vs_o, lost_o;
  logic [7:0] width_o;
  logic       hs_inv = 1'b0, vs_inv = 1'b0;

  int vecs = 0, fails = 0;

  always #5 clk = ~clk;

  sync_conditioner i_sync_conditioner (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .hs_i         (hs_d),
    .vs_i         (vs_d),
    .hs_in_neg_i  (hs_in_neg),
    .vs_in_neg_i  (vs_in_neg),
    .hs_out_neg_i (hs_out_neg),
    .vs_out_neg_i (vs_out_neg),
    .vs_lines_i   (lines_cfg),
    .timeout_i    (to_cfg),
    .hs_o         (hs_o),
    .vs_o         (vs_o),
    .vs_width_o   (width_o),
    .hs_lost_o    (lost_o)
  );

  // output monitor, positive polarity assumed while mon_en is set
  bit mon_en = 1'b1;
  bit hs_p = 1'b0, vs_p = 1'b0;
  int pulses = 0, line_cnt = 0, last_lines = 0, misalign = 0;
  int hs_w = 0, last_hs_w = 0, low_run = 0, last_low = 0;

  always @(negedge clk) begin
    bit hs_edge;
    hs_edge = hs_o && !hs_p;
    if (rst_n) begin
      if (vs_o == 1'b0) low_run++;
      else begin
        if (low_run != 0) last_low = low_run;
        low_run = 0;
      end
      if (mon_en) begin
        if (hs_edge) hs_w = 1;
        else if (hs_o) hs_w++;
        if (!hs_o && hs_p) last_hs_w = hs_w;
        if (vs_o && !vs_p) begin
          pulses++;
          line_cnt = 0;
          if (!hs_edge) misalign++;
        end
        if (vs_o && hs_edge) line_cnt++;
        if (!vs_o && vs_p) begin
          last_lines = line_cnt;
          if (!hs_edge) misalign++;
        end
      end
    end
    hs_p = hs_o;
    vs_p = vs_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_lines(input int n, input int von, input int vlen, input int vph);
    for (int l = 0; l < n; l++) begin
      for (int c = 0; c < LINE; c++) begin
        int t = l * LINE + c;
        @(negedge clk);
        hs_d = (c < HSW) ^ hs_inv;
        vs_d = ((vlen > 0) && (t >= von * LINE + vph) && (t < (von + vlen) * LINE + vph)) ^ vs_inv;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R1 hs_o", hs_o, 0);
    chk("R1 vs_o", vs_o, 0);
    chk("R1 width", width_o, 0);
    chk("R1 lost", lost_o, 0);
  endtask

  task automatic t_timeout_off;
    idle(1000);
    chk("R10 disabled timeout", lost_o, 0);
  endtask

  task automatic t_long_frame;
    int p0 = pulses;
    run_lines(24, 4, 15, 20);
    chk("R6 one pulse per long input", pulses - p0, 1);
    chk("R4 pulse lines", last_lines, 4);
    chk("R5 misalign", misalign, 0);
    chk("R9 width 15", width_o, 15);
    chk("R3 hsync width", last_hs_w, HSW);
  endtask

  task automatic t_short_frame;
    int p0 = pulses;
    run_lines(16, 4, 2, 20);
    chk("R6 one pulse per short input", pulses - p0, 1);
    chk("R6 short input full length", last_lines, 4);
    chk("R9 width 2", width_o, 2);
  endtask

  task automatic t_coincident;
    int p0 = pulses;
    run_lines(16, 4, 3, 0);
    chk("R5 coincident pulse", pulses - p0, 1);
    chk("R5 coincident lines", last_lines, 4);
    chk("R5 coincident misalign", misalign, 0);
    chk("R9 coincident width", width_o, 3);
  endtask

  task automatic t_line_cfg;
    lines_cfg = 8'd6;
    run_lines(24, 4, 15, 20);
    chk("R4 six lines", last_lines, 6);
    lines_cfg = 8'd0;
    run_lines(16, 4, 15, 20);
    chk("R4 zero acts as one", last_lines, 1);
    lines_cfg = 8'd4;
  endtask

  task automatic t_glitch;
    int highs = 0;
    int p0 = pulses;
    hs_d = 1'b1;
    idle(2);
    hs_d = 1'b0;
    repeat (12) begin
      @(negedge clk);
      if (hs_o) highs++;
    end
    chk("R2 hsync glitch", highs, 0);
    vs_d = 1'b1;
    idle(2);
    vs_d = 1'b0;
    run_lines(8, 0, 0, 0);
    chk("R2 vsync glitch", pulses - p0, 0);
  endtask

  task automatic t_input_inv;
    int p0 = pulses;
    @(negedge clk);
    hs_inv = 1'b1; vs_inv = 1'b1;
    hs_in_neg = 1'b1; vs_in_neg = 1'b1;
    hs_d = ~hs_d; vs_d = ~vs_d;
    run_lines(24, 4, 15, 20);
    chk("R8 inverted source pulse", pulses - p0, 1);
    chk("R8 inverted source lines", last_lines, 4);
    chk("R8 inverted source width", width_o, 15);
    @(negedge clk);
    hs_inv = 1'b0; vs_inv = 1'b0;
    hs_in_neg = 1'b0; vs_in_neg = 1'b0;
    hs_d = ~hs_d; vs_d = ~vs_d;
  endtask

  task automatic t_out_pol;
    mon_en = 1'b0;
    hs_out_neg = 1'b1; vs_out_neg = 1'b1;
    run_lines(3, 0, 0, 0);
    chk("R7 hs held before frame", hs_o, 0);
    chk("R7 vs held before frame", vs_o, 0);
    run_lines(24, 4, 15, 20);
    chk("R7 hs inverted idle", hs_o, 1);
    chk("R7 vs inverted idle", vs_o, 1);
    chk("R7 active-low vs length", last_low, 4 * LINE);
    hs_out_neg = 1'b0; vs_out_neg = 1'b0;
    run_lines(24, 4, 15, 20);
    chk("R7 restored hs", hs_o, 0);
    chk("R7 restored vs", vs_o, 0);
    mon_en = 1'b1;
  endtask

  task automatic t_lost;
    int p0;
    to_cfg = 8'd2;
    idle(400);
    chk("R10 short gap", lost_o, 0);
    run_lines(2, 0, 0, 0);
    idle(700);
    chk("R10 long gap", lost_o, 1);
    p0 = pulses;
    run_lines(24, 4, 15, 20);
    chk("R10 vs forced off", pulses - p0, 0);
    chk("R10 sticky", lost_o, 1);
    to_cfg = 8'd0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_timeout_off();
    t_long_frame();
    t_short_frame();
    t_coincident();
    t_line_cfg();
    t_glitch();
    t_input_inv();
    t_out_pol();
    t_lost();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule